// File: doc/BRIEF.md
# Home-node full-map coherence directory

This block is the home node of a small shared-memory system with P processor caches. For every memory block it holds a bit vector of the caches that have a copy and a dirty flag that marks one of those caches as the owner. It also holds the memory data itself. Caches send it read misses, write misses and writebacks as single-cycle messages. The directory answers with data, an acknowledgement or a negative acknowledgement. When a request needs a coherence round, the directory sends RECALL or INVALIDATE messages only to the caches recorded as holders. It then gathers their ACK or ACK_DATA answers, writes any returned data into memory and replies to the requester.

Each message carries a 3-bit type, a source id, a destination id, a block index and a data word. Ids 0 to P-1 are the caches and id P is the directory. A RECALL tells the owner to write its line back and keep a clean shared copy. An INVALIDATE tells the cache to drop its copy. An owner answers either message with ACK_DATA carrying its line. A clean sharer answers an INVALIDATE with ACK. Only one coherence round is in flight at a time. During a round, requests that can be served at once still proceed.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, no message is output until a request arrives. Every block is clean and has no holder, and every memory word is zero.
- R2: A read miss to a clean block is answered on the output in the cycle after the request. The answer is DATA_REPLY (7) to the requester with the memory word, and the requester is recorded as a holder.
- R3: A read miss to a block owned by another cache causes one RECALL (3), sent only to the owner. After the owner's ACK_DATA (5), the returned word is written to memory and sent as DATA_REPLY to the requester. The block becomes clean, so a later read from a third cache is answered directly with that word and no RECALL.
- R4: A write miss to a block held by other caches causes one INVALIDATE (4) to each of those other holders, lowest id first. No INVALIDATE goes to the requester or to a non-holder. The DATA_REPLY is held back until every holder has answered with ACK (6) or ACK_DATA.
- R5: A write miss to a block owned by another cache sends INVALIDATE to the owner. The owner's ACK_DATA word is written to memory and granted to the requester. The requester becomes the only holder and the owner.
- R6: A writeback (2) from the owner writes its data to memory and is answered with ACK. It clears the dirty flag and that cache's holder bit, so a later read is answered directly with the written word.
- R7: A writeback from a cache that is not the owner is answered with ACK and changes neither memory nor the directory.
- R8: While a coherence round is pending on a block, any request to that block is answered next cycle with out_nack=1, out_type equal to the request type, and the requester as destination.
- R9: While a round is pending, a request to another block that needs no round is served normally.
- R10: While a round is pending, a request to another block that would need its own round is answered with a NACK.
- R11: A dirty block always has exactly one holder, so a read to it produces exactly one RECALL.
- R12: Message types are encoded READ_MISS=0, WRITE_MISS=1, WRITEBACK=2, RECALL=3, INVALIDATE=4, ACK_DATA=5, ACK=6, DATA_REPLY=7. Every output message has source id P. ACK, NACK, RECALL and INVALIDATE carry data zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An incoming message is present this cycle |
| in_type | input | 3 | Incoming message type |
| in_src | input | $clog2(P)+1 | Sending cache id |
| in_blk | input | $clog2(BLOCKS) | Block index |
| in_data | input | DW | Data of a writeback or ACK_DATA |
| out_valid | output | 1 | An outgoing message is present this cycle |
| out_nack | output | 1 | Outgoing message is a negative acknowledgement |
| out_type | output | 3 | Outgoing message type |
| out_src | output | $clog2(P)+1 | Always the directory id P |
| out_dst | output | $clog2(P)+1 | Destination cache id |
| out_blk | output | $clog2(BLOCKS) | Block index |
| out_data | output | DW | Reply data |

## Verification
The hardest state to reach is a coherence round held open while other traffic arrives. The bench models the caches and withholds their acknowledgements. Once the invalidations for a write miss to a shared block have come out, it sends, before any acknowledgement, a read and a writeback to the same block, a read and a write to blocks that need no round, and a write to another shared block. It then releases the acknowledgements one at a time and checks that the grant appears only after the last one. The bench also makes a stale writeback arrive from a cache that has just lost ownership, then reads the block and checks which cache receives the RECALL.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int P = 4,
  parameter int BLOCKS = 16,
  parameter int DW = 32,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int IDW = PW + 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2:0]     in_type,
  input  logic [IDW-1:0] in_src,
  input  logic [BW-1:0]  in_blk,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  output logic           out_nack,
  output logic [2:0]     out_type,
  output logic [IDW-1:0] out_src,
  output logic [IDW-1:0] out_dst,
  output logic [BW-1:0]  out_blk,
  output logic [DW-1:0]  out_data
);

  localparam logic [2:0] M_RD   = 3'd0;
  localparam logic [2:0] M_WR   = 3'd1;
  localparam logic [2:0] M_WB   = 3'd2;
  localparam logic [2:0] M_RCL  = 3'd3;
  localparam logic [2:0] M_INV  = 3'd4;
  localparam logic [2:0] M_ACKD = 3'd5;
  localparam logic [2:0] M_ACK  = 3'd6;
  localparam logic [2:0] M_DRPL = 3'd7;
  localparam logic [IDW-1:0] HOME = IDW'(P);

  typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT, E_REPLY} eng_t;

  logic [DW-1:0]     mem  [BLOCKS];
  logic [P-1:0]      pres [BLOCKS];
  logic [BLOCKS-1:0] dirty;

  eng_t          eng;
  logic          rd_round;
  logic [PW-1:0] req_src;
  logic [BW-1:0] req_blk;
  logic [P-1:0]  send_mask, wait_mask;
  logic [PW-1:0] nxt;

  assign out_src = HOME;

  wire          src_ok = in_src < HOME;
  wire [PW-1:0] s      = in_src[PW-1:0];
  wire          is_req = in_valid && src_ok &&
                         (in_type == M_RD || in_type == M_WR || in_type == M_WB);
  wire          is_ack = in_valid && src_ok && (in_type == M_ACK || in_type == M_ACKD) &&
                         eng != E_IDLE && in_blk == req_blk && wait_mask[s];

  wire [P-1:0] cur_pres  = pres[in_blk];
  wire         cur_dirty = dirty[in_blk];
  wire [P-1:0] me        = P'(1) << s;
  wire [P-1:0] others    = cur_pres & ~me;

  wire blk_busy      = eng != E_IDLE && in_blk == req_blk;
  wire need_rd_round = in_type == M_RD && cur_dirty && !cur_pres[s];
  wire need_wr_round = in_type == M_WR && others != '0;
  wire need_round    = need_rd_round || need_wr_round;

  wire nack        = is_req && (blk_busy || (need_round && eng != E_IDLE));
  wire start_round = is_req && !nack && need_round;
  wire serve       = is_req && !nack && !need_round;
  wire resp_now    = nack || serve;
  wire wb_hit      = in_type == M_WB && cur_dirty && cur_pres[s];

  wire [P-1:0] round_mask = need_rd_round ? cur_pres : others;

  always_comb begin
    nxt = '0;
    for (int k = P - 1; k >= 0; k--)
      if (send_mask[k]) nxt = PW'(k);
  end

  wire [P-1:0] nxt_bit   = P'(1) << nxt;
  wire         eng_emit  = eng == E_SEND && !resp_now;
  wire         eng_reply = eng == E_REPLY && !resp_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nack  <= 1'b0;
      out_type  <= M_RD;
      out_dst   <= '0;
      out_blk   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= resp_now || eng_emit || eng_reply;
      out_nack  <= 1'b0;
      if (resp_now) begin
        out_nack <= nack;
        out_type <= nack ? in_type : (in_type == M_WB ? M_ACK : M_DRPL);
        out_dst  <= in_src;
        out_blk  <= in_blk;
        out_data <= (nack || in_type == M_WB) ? '0 : mem[in_blk];
      end else if (eng_emit) begin
        out_type <= rd_round ? M_RCL : M_INV;
        out_dst  <= {1'b0, nxt};
        out_blk  <= req_blk;
        out_data <= '0;
      end else if (eng_reply) begin
        out_type <= M_DRPL;
        out_dst  <= {1'b0, req_src};
        out_blk  <= req_blk;
        out_data <= mem[req_blk];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        mem[b]  <= '0;
        pres[b] <= '0;
      end
      dirty     <= '0;
      eng       <= E_IDLE;
      rd_round  <= 1'b0;
      req_src   <= '0;
      req_blk   <= '0;
      send_mask <= '0;
      wait_mask <= '0;
    end else begin
      if (serve) begin
        case (in_type)
          M_RD: pres[in_blk] <= cur_pres | me;
          M_WR: begin
            pres[in_blk]  <= me;
            dirty[in_blk] <= 1'b1;
          end
          default: if (wb_hit) begin
            mem[in_blk]   <= in_data;
            pres[in_blk]  <= cur_pres & ~me;
            dirty[in_blk] <= 1'b0;
          end
        endcase
      end
      if (is_ack) begin
        wait_mask[s] <= 1'b0;
        if (in_type == M_ACKD) mem[req_blk] <= in_data;
      end
      case (eng)
        E_IDLE: if (start_round) begin
          eng       <= E_SEND;
          rd_round  <= in_type == M_RD;
          req_src   <= s;
          req_blk   <= in_blk;
          send_mask <= round_mask;
          wait_mask <= round_mask;
        end
        E_SEND: if (eng_emit) begin
          send_mask <= send_mask & ~nxt_bit;
          if ((send_mask & ~nxt_bit) == '0) eng <= E_WAIT;
        end
        E_WAIT: if (wait_mask == '0) eng <= E_REPLY;
        default: if (eng_reply) begin
          eng <= E_IDLE;
          if (rd_round) begin
            pres[req_blk]  <= pres[req_blk] | (P'(1) << req_src);
            dirty[req_blk] <= 1'b0;
          end else begin
            pres[req_blk]  <= P'(1) << req_src;
            dirty[req_blk] <= 1'b1;
          end
        end
      endcase
    end
  end

  // R11
  dirty_one_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dirty[in_blk]) |-> $countones(pres[in_blk]) == 1);

  // R8
  nack_answers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nack) |-> $past(is_req));

  // R4
  no_inv_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nack && (out_type == M_RCL || out_type == M_INV)) |->
      (out_dst != {1'b0, req_src} && eng != E_IDLE));

  // R4
  idle_masks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng == E_IDLE) |-> (send_mask == '0 && wait_mask == '0));

  // R12
  dst_is_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dst < HOME);

endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int P = 4, BLOCKS = 16, DW = 32, IDW = 3, BW = 4;
  localparam logic [2:0] RD = 0, WR = 1, WB = 2, RCL = 3, INV = 4, ACKD = 5, ACK = 6, DRPL = 7;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [2:0] in_type = 0;
  logic [IDW-1:0] in_src = 0;
  logic [BW-1:0] in_blk = 0;
  logic [DW-1:0] in_data = 0;
  logic out_valid, out_nack;
  logic [2:0] out_type;
  logic [IDW-1:0] out_src, out_dst;
  logic [BW-1:0] out_blk;
  logic [DW-1:0] out_data;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dir_home_ctrl #(.P(P), .BLOCKS(BLOCKS), .DW(DW)) i_dir_home_ctrl (
    .clk, .rst_n, .in_valid, .in_type, .in_src, .in_blk, .in_data,
    .out_valid, .out_nack, .out_type, .out_src, .out_dst, .out_blk, .out_data);

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] t, input int src, input int blk, input logic [DW-1:0] d);
    in_valid = 1; in_type = t; in_src = IDW'(src); in_blk = BW'(blk); in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_msg(input string tag, input bit nk, input logic [2:0] t, input int dst,
                            input int blk, input logic [DW-1:0] d, input bit at_once);
    int waited = 0;
    while (!out_valid && waited < 30) begin
      @(negedge clk);
      waited++;
    end
    if (!out_valid) begin
      check(0, tag, "no message", $sformatf("type %0d dst %0d", t, dst));
    end else begin
      check(out_nack == nk && out_type == t && out_dst == IDW'(dst) && out_blk == BW'(blk) &&
            out_data == d && out_src == IDW'(P) && (!at_once || waited == 0), tag,
            $sformatf("nack %0b type %0d src %0d dst %0d blk %0d data %h wait %0d",
                      out_nack, out_type, out_src, out_dst, out_blk, out_data, waited),
            $sformatf("nack %0b type %0d src %0d dst %0d blk %0d data %h wait 0%s",
                      nk, t, P, dst, blk, d, at_once ? "" : " or more"));
      @(negedge clk);
    end
  endtask

  task automatic expect_quiet(input string tag, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      if (out_valid) seen = 1;
      @(negedge clk);
    end
    check(!seen, tag, "message seen", "no message");
  endtask

  task automatic t_reset();
    expect_quiet("R1 quiet after reset", 5);
    send(RD, 0, 0, 0);
    expect_msg("R1 R2 R12 read block 0", 0, DRPL, 0, 0, 0, 1);
  endtask

  task automatic t_clean_read();
    send(RD, 1, 3, 0);
    expect_msg("R2 read node1 blk3", 0, DRPL, 1, 3, 0, 1);
    send(RD, 2, 3, 0);
    expect_msg("R2 read node2 blk3", 0, DRPL, 2, 3, 0, 1);
  endtask

  task automatic t_write_sharers();
    send(WR, 0, 3, 0);
    expect_msg("R4 inv to node1", 0, INV, 1, 3, 0, 0);
    expect_msg("R4 inv to node2", 0, INV, 2, 3, 0, 1);
    expect_quiet("R4 no grant before acks", 3);
    send(ACK, 1, 3, 0);
    expect_quiet("R4 no grant after first ack", 3);
    send(ACK, 2, 3, 0);
    expect_msg("R4 grant after last ack", 0, DRPL, 0, 3, 0, 0);
  endtask

  task automatic t_wb_owner();
    send(WB, 0, 3, 32'hA5A5_0003);
    expect_msg("R6 writeback ack", 0, ACK, 0, 3, 0, 1);
    send(RD, 1, 3, 0);
    expect_msg("R6 read after writeback, no recall", 0, DRPL, 1, 3, 32'hA5A5_0003, 1);
  endtask

  task automatic t_dirty_read();
    send(WR, 3, 5, 0);
    expect_msg("R5 write grant no holders", 0, DRPL, 3, 5, 0, 1);
    send(RD, 1, 5, 0);
    expect_msg("R3 R11 recall to owner 3", 0, RCL, 3, 5, 0, 0);
    expect_quiet("R11 single recall", 3);
    send(ACKD, 3, 5, 32'h1234_5555);
    expect_msg("R3 reply recalled data", 0, DRPL, 1, 5, 32'h1234_5555, 0);
    send(RD, 2, 5, 0);
    expect_msg("R3 memory updated, block clean", 0, DRPL, 2, 5, 32'h1234_5555, 1);
  endtask

  task automatic t_write_dirty();
    send(WR, 1, 7, 0);
    expect_msg("R5 first owner grant", 0, DRPL, 1, 7, 0, 1);
    send(WR, 2, 7, 0);
    expect_msg("R5 inv to owner 1", 0, INV, 1, 7, 0, 0);
    send(ACKD, 1, 7, 32'h7777_0001);
    expect_msg("R5 grant owner data", 0, DRPL, 2, 7, 32'h7777_0001, 0);
    send(WB, 1, 7, 32'h0000_DEAD);
    expect_msg("R7 stale writeback ack", 0, ACK, 1, 7, 0, 1);
    send(RD, 0, 7, 0);
    expect_msg("R7 R11 recall goes to new owner 2", 0, RCL, 2, 7, 0, 0);
    send(ACKD, 2, 7, 32'h7777_0002);
    expect_msg("R7 reply data from owner 2", 0, DRPL, 0, 7, 32'h7777_0002, 0);
  endtask

  task automatic t_stale_clean();
    send(WB, 2, 11, 32'h0000_0BAD);
    expect_msg("R7 writeback to clean block ack", 0, ACK, 2, 11, 0, 1);
    send(RD, 3, 11, 0);
    expect_msg("R7 memory unchanged", 0, DRPL, 3, 11, 0, 1);
  endtask

  task automatic t_busy();
    send(RD, 1, 9, 0);
    expect_msg("R2 setup read node1", 0, DRPL, 1, 9, 0, 1);
    send(RD, 2, 9, 0);
    expect_msg("R2 setup read node2", 0, DRPL, 2, 9, 0, 1);
    send(WR, 0, 9, 0);
    expect_msg("R4 inv node1 blk9", 0, INV, 1, 9, 0, 0);
    expect_msg("R4 inv node2 blk9", 0, INV, 2, 9, 0, 1);
    send(RD, 3, 9, 0);
    expect_msg("R8 nack read busy block", 1, RD, 3, 9, 0, 1);
    send(WB, 3, 9, 32'h1);
    expect_msg("R8 nack writeback busy block", 1, WB, 3, 9, 0, 1);
    send(RD, 3, 10, 0);
    expect_msg("R9 other block read served", 0, DRPL, 3, 10, 0, 1);
    send(WR, 2, 3, 0);
    expect_msg("R10 second round nacked", 1, WR, 2, 3, 0, 1);
    send(WR, 3, 12, 0);
    expect_msg("R9 other block write served", 0, DRPL, 3, 12, 0, 1);
    send(ACK, 1, 9, 0);
    send(ACK, 2, 9, 0);
    expect_msg("R4 grant blk9", 0, DRPL, 0, 9, 0, 0);
    send(RD, 3, 9, 0);
    expect_msg("R8 retry now recalls owner 0", 0, RCL, 0, 9, 0, 0);
    send(ACKD, 0, 9, 32'h0000_0099);
    expect_msg("R8 retry served", 0, DRPL, 3, 9, 32'h0000_0099, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 reset output", $sformatf("%0b", out_valid), "0");
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean_read();
    t_write_sharers();
    t_wb_owner();
    t_dirty_read();
    t_write_dirty();
    t_stale_clean();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule